// File: doc/BRIEF.md
# Comparator-Driven Clock Interrupt Sequencer

This block rebuilds three time-of-day chip interrupts from one comparator channel that watches an external free-running 32-bit tick counter. The three interrupts are a once-per-second update, a time-of-day alarm and a periodic interrupt with a programmable rate. The comparator fires at a base poll rate of 64 matches per second. On each match the update and alarm conditions are sampled against the current hours, minutes and seconds. A divider, or a shorter interval for high rates, produces the periodic interrupt.

After each match the comparator is pushed forward by one interval at a time, one step per clock. It stops once its target lies strictly ahead of the counter, using a signed difference so that counter wraparound is harmless. Every step beyond the first is a lost interrupt. The lost count saturates, is shown on a port and is credited to the periodic divider. The three flags and a combined request bit are sticky and are cleared by an acknowledge pulse. The number of ticks per base interval is a parameter, so the conversion from rates to ticks happens outside the block.

Top module: `clk_irq_emu`

## Requirements
- R1: After reset all three flags, the request bit and the lost count read zero.
- R2: When any interrupt kind becomes enabled while all were off, the comparator is armed at the counter value plus the current interval. The first match occurs when the counter reaches that value, not one tick earlier.
- R3: A match occurs only when the signed 32-bit value (counter minus target) is zero or positive. A counter just below the wrap point does not match a target that has wrapped past zero.
- R4: After a match the target is advanced by one interval repeatedly until it is strictly ahead of the counter. `lost_o` then shows the number of advances beyond the first, and the next match occurs at the final target.
- R5: The lost count saturates at 2^LOST_W-1 (255 by default) instead of wrapping.
- R6: With update enabled, the first match after enabling only records the seconds value and does not fire. A later match fires the update flag only if the seconds value differs from the one recorded at the previous match.
- R7: With alarm enabled, a match fires the alarm flag when hours, minutes and seconds all equal the alarm inputs. If any field differs, it does not fire.
- R8: `rate_i` holds log2 of the periodic rate, clamped to 1..13 (2 to 8192 per second). At a code of 6 or less, the periodic flag fires once every 2^(6-code) base matches.
- R9: At a code above 6 with periodic enabled, the interval is BASE_TICKS >> (code-6) ticks, and the periodic flag fires on every match.
- R10: When periodic is enabled, lost interrupts are added to the divider count together with the match itself.
- R11: With no interrupt kind enabled the comparator is off: no match occurs, no flag fires, and the lost count does not change.
- R12: Any flag that fires also sets `irq_o`. Flags and `irq_o` stay set until an `ack_i` pulse clears all of them, and a new event in the same cycle as the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | CNT_W | Free-running tick counter |
| hour_i | input | 5 | Current hours |
| min_i | input | 6 | Current minutes |
| sec_i | input | 6 | Current seconds |
| en_upd_i | input | 1 | Enable the seconds-update interrupt |
| en_alm_i | input | 1 | Enable the alarm interrupt |
| en_per_i | input | 1 | Enable the periodic interrupt |
| alm_hour_i | input | 5 | Alarm hours |
| alm_min_i | input | 6 | Alarm minutes |
| alm_sec_i | input | 6 | Alarm seconds |
| rate_i | input | 4 | log2 of the periodic rate |
| ack_i | input | 1 | Clears all flags and the request bit |
| flag_upd_o | output | 1 | Sticky update flag |
| flag_alm_o | output | 1 | Sticky alarm flag |
| flag_per_o | output | 1 | Sticky periodic flag |
| irq_o | output | 1 | Sticky combined interrupt request |
| lost_o | output | LOST_W | Lost interrupts at the most recent match |

## Verification
The bench arms the comparator just below the 32-bit wrap point. An unsigned compare would fire at once there, while the signed compare waits until the wrapped target. It jumps the counter several intervals ahead to check the re-arm loop. An off-by-one there would show a wrong lost count or move the next match by one interval, and 300 missed intervals expose a lost counter that wraps instead of saturating. Periodic checks pick a divider of 8 with four lost intervals, so a design that ignores the lost credit fires four matches late. The update check confirms that the first sample after enabling stays silent. It also confirms that re-enabling from the all-off state re-arms relative to the present counter value rather than a stale target.

// File: rtl/clk_irq_emu_pkg.sv
package clk_irq_emu_pkg;
  localparam int HR_W = 5;
  localparam int MN_W = 6;
  localparam int SC_W = 6;
  localparam int RATE_W = 4;

  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_ARMED = 2'd1,
    SCH_REARM = 2'd2
  } sch_state_e;
endpackage

// File: rtl/cmp_sched.sv
module cmp_sched
  import clk_irq_emu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LOST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  intv_i,
  output logic              hit_o,
  output logic              done_o,
  output logic              idle_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [LOST_W-1:0] miss_o
);
  localparam logic [LOST_W-1:0] MISS_MAX = {LOST_W{1'b1}};

  sch_state_e        state_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [LOST_W-1:0] miss_q;
  logic [CNT_W-1:0]  diff;
  logic              reached;

  // wrap-safe: target reached when signed(count - cmp) >= 0
  assign diff    = count_i - cmp_q;
  assign reached = ~diff[CNT_W-1];

  assign hit_o  = run_i && (state_q == SCH_ARMED) && reached;
  assign done_o = run_i && (state_q == SCH_REARM) && !reached;
  assign idle_o = (state_q == SCH_IDLE);
  assign cmp_o  = cmp_q;
  assign miss_o = miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SCH_IDLE;
      cmp_q   <= '0;
      miss_q  <= '0;
    end else if (!run_i) begin
      state_q <= SCH_IDLE;
    end else begin
      unique case (state_q)
        SCH_IDLE: begin
          cmp_q   <= count_i + intv_i;
          state_q <= SCH_ARMED;
        end
        SCH_ARMED: if (reached) begin
          cmp_q   <= cmp_q + intv_i;
          miss_q  <= '0;
          state_q <= SCH_REARM;
        end
        SCH_REARM: begin
          if (reached) begin
            cmp_q <= cmp_q + intv_i;
            if (miss_q != MISS_MAX) miss_q <= miss_q + 1'b1;
          end else begin
            state_q <= SCH_ARMED;
          end
        end
        default: state_q <= SCH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tod_check.sv
module tod_check
  import clk_irq_emu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  logic            en_upd_i,
  input  logic            en_alm_i,
  input  logic [HR_W-1:0] hour_i,
  input  logic [MN_W-1:0] min_i,
  input  logic [SC_W-1:0] sec_i,
  input  logic [HR_W-1:0] alm_hour_i,
  input  logic [MN_W-1:0] alm_min_i,
  input  logic [SC_W-1:0] alm_sec_i,
  output logic            upd_evt_o,
  output logic            alm_evt_o
);
  logic [SC_W-1:0] prev_sec_q;
  logic            seen_q;

  assign upd_evt_o = hit_i && en_upd_i && seen_q && (sec_i != prev_sec_q);
  assign alm_evt_o = hit_i && en_alm_i && (hour_i == alm_hour_i) &&
                     (min_i == alm_min_i) && (sec_i == alm_sec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sec_q <= '0;
      seen_q     <= 1'b0;
    end else if (!en_upd_i) begin
      seen_q <= 1'b0;
    end else if (hit_i) begin
      prev_sec_q <= sec_i;
      seen_q     <= 1'b1;
    end
  end
endmodule

// File: rtl/per_div.sv
module per_div
  import clk_irq_emu_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LOST_W     = 8,
  parameter int BASE_TICKS = 1024,
  parameter int BASE_LOG2  = 6,
  parameter int MAX_LOG2   = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_per_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              done_i,
  input  logic [LOST_W-1:0] miss_i,
  output logic [CNT_W-1:0]  intv_o,
  output logic              per_evt_o
);
  localparam int SUM_W = ((LOST_W > BASE_LOG2) ? LOST_W : BASE_LOG2) + 2;
  localparam logic [RATE_W-1:0] BASE_R = RATE_W'(BASE_LOG2);
  localparam logic [RATE_W-1:0] MAX_R  = RATE_W'(MAX_LOG2);

  logic [RATE_W-1:0] rate;
  logic [SUM_W-1:0]  limit;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  cnt_q;
  logic              fast;

  always_comb begin
    if (rate_i == '0)        rate = RATE_W'(1);
    else if (rate_i > MAX_R) rate = MAX_R;
    else                     rate = rate_i;
  end

  assign fast   = rate > BASE_R;
  assign limit  = fast ? SUM_W'(1) : (SUM_W'(1) << (BASE_R - rate));
  assign intv_o = (en_per_i && fast) ? (CNT_W'(BASE_TICKS) >> (rate - BASE_R))
                                     : CNT_W'(BASE_TICKS);
  assign sum       = cnt_q + SUM_W'(1) + SUM_W'(miss_i);
  assign per_evt_o = done_i && en_per_i && (sum >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_per_i)   cnt_q <= '0;
    else if (done_i)      cnt_q <= per_evt_o ? '0 : sum;
  end
endmodule

// File: rtl/clk_irq_emu.sv
module clk_irq_emu
  import clk_irq_emu_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int LOST_W     = 8,
  parameter int BASE_TICKS = 1024,
  parameter int BASE_LOG2  = 6,
  parameter int MAX_LOG2   = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [4:0]        hour_i,
  input  logic [5:0]        min_i,
  input  logic [5:0]        sec_i,
  input  logic              en_upd_i,
  input  logic              en_alm_i,
  input  logic              en_per_i,
  input  logic [4:0]        alm_hour_i,
  input  logic [5:0]        alm_min_i,
  input  logic [5:0]        alm_sec_i,
  input  logic [3:0]        rate_i,
  input  logic              ack_i,
  output logic              flag_upd_o,
  output logic              flag_alm_o,
  output logic              flag_per_o,
  output logic              irq_o,
  output logic [LOST_W-1:0] lost_o
);
  logic              run, hit, done, idle;
  logic [CNT_W-1:0]  cmp, intv;
  logic [LOST_W-1:0] miss;
  logic              upd_evt, alm_evt, per_evt;

  assign run = en_upd_i | en_alm_i | en_per_i;

  cmp_sched #(.CNT_W(CNT_W), .LOST_W(LOST_W)) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .count_i(count_i),
    .intv_i(intv), .hit_o(hit), .done_o(done), .idle_o(idle),
    .cmp_o(cmp), .miss_o(miss)
  );

  tod_check u_tod (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit),
    .en_upd_i(en_upd_i), .en_alm_i(en_alm_i),
    .hour_i(hour_i), .min_i(min_i), .sec_i(sec_i),
    .alm_hour_i(alm_hour_i), .alm_min_i(alm_min_i), .alm_sec_i(alm_sec_i),
    .upd_evt_o(upd_evt), .alm_evt_o(alm_evt)
  );

  per_div #(
    .CNT_W(CNT_W), .LOST_W(LOST_W), .BASE_TICKS(BASE_TICKS),
    .BASE_LOG2(BASE_LOG2), .MAX_LOG2(MAX_LOG2)
  ) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_per_i(en_per_i), .rate_i(rate_i),
    .done_i(done), .miss_i(miss), .intv_o(intv), .per_evt_o(per_evt)
  );

  // sticky flags; a same-cycle event beats the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_upd_o <= 1'b0;
      flag_alm_o <= 1'b0;
      flag_per_o <= 1'b0;
      irq_o      <= 1'b0;
      lost_o     <= '0;
    end else begin
      flag_upd_o <= (flag_upd_o & ~ack_i) | upd_evt;
      flag_alm_o <= (flag_alm_o & ~ack_i) | alm_evt;
      flag_per_o <= (flag_per_o & ~ack_i) | per_evt;
      irq_o      <= (irq_o & ~ack_i) | upd_evt | alm_evt | per_evt;
      if (done) lost_o <= miss;
    end
  end
endmodule

// File: rtl/clk_irq_emu_chk.sv
module clk_irq_emu_chk #(
  parameter int CNT_W  = 32,
  parameter int LOST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              hit_i,
  input logic              done_i,
  input logic              idle_i,
  input logic [CNT_W-1:0]  cmp_i,
  input logic [CNT_W-1:0]  intv_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              en_alm_i,
  input logic              ack_i,
  input logic              flag_upd_i,
  input logic              flag_alm_i,
  input logic              flag_per_i,
  input logic              irq_i,
  input logic [LOST_W-1:0] lost_i
);
  p_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && run_i) |=> (cmp_i == $past(count_i + intv_i)));

  p_quiet_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!hit_i && !done_i));

  p_irq_follows_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_upd_i) || $rose(flag_alm_i) || $rose(flag_per_i)) |-> irq_i);

  p_ack_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit_i && !done_i) |=> !irq_i);

  p_alarm_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_alm_i) |-> $past(en_alm_i));

  p_per_on_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_per_i) |-> $past(done_i));

  p_lost_on_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lost_i) |-> $past(done_i));
endmodule

bind clk_irq_emu clk_irq_emu_chk #(.CNT_W(CNT_W), .LOST_W(LOST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .hit_i(hit), .done_i(done),
  .idle_i(idle), .cmp_i(cmp), .intv_i(intv), .count_i(count_i),
  .en_alm_i(en_alm_i), .ack_i(ack_i), .flag_upd_i(flag_upd_o),
  .flag_alm_i(flag_alm_o), .flag_per_i(flag_per_o), .irq_i(irq_o),
  .lost_i(lost_o)
);

// File: tb/tb_clk_irq_emu.sv
module tb_clk_irq_emu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] count;
  logic [4:0]  hour, alm_hour;
  logic [5:0]  min, sec, alm_min, alm_sec;
  logic        en_upd, en_alm, en_per, ack;
  logic [3:0]  rate;
  logic        flag_upd, flag_alm, flag_per, irq;
  logic [7:0]  lost;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  clk_irq_emu dut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count),
    .hour_i(hour), .min_i(min), .sec_i(sec),
    .en_upd_i(en_upd), .en_alm_i(en_alm), .en_per_i(en_per),
    .alm_hour_i(alm_hour), .alm_min_i(alm_min), .alm_sec_i(alm_sec),
    .rate_i(rate), .ack_i(ack),
    .flag_upd_o(flag_upd), .flag_alm_o(flag_alm), .flag_per_o(flag_per),
    .irq_o(irq), .lost_o(lost)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; count = '0; ack = 1'b0;
    en_upd = 1'b0; en_alm = 1'b0; en_per = 1'b0; rate = 4'd6;
    hour = 5'd10; min = 6'd20; sec = 6'd30;
    alm_hour = 5'd10; alm_min = 6'd20; alm_sec = 6'd30;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cnt(input logic [31:0] v);
    @(negedge clk);
    count = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flag_upd", flag_upd, 0);
    chk("R1 flag_alm", flag_alm, 0);
    chk("R1 flag_per", flag_per, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lost", lost, 0);
  endtask

  task automatic t_arm();
    do_reset();
    count = 32'd1000;
    @(negedge clk); en_alm = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd2023);
    chk("R2 no match one tick early", flag_alm, 0);
    set_cnt(32'd2024);
    chk("R2 match at count+interval", flag_alm, 1);
    chk("R12 irq with flag", irq, 1);
    repeat (10) @(negedge clk);
    chk("R12 flag sticky", flag_alm, 1);
    pulse_ack();
    chk("R12 ack clears flag", flag_alm, 0);
    chk("R12 ack clears irq", irq, 0);
  endtask

  task automatic t_alarm_mismatch();
    do_reset();
    alm_min = 6'd21;
    @(negedge clk); en_alm = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd1024);
    chk("R7 minute mismatch no alarm", flag_alm, 0);
    @(negedge clk); min = 6'd21;
    set_cnt(32'd2048);
    chk("R7 all fields equal", flag_alm, 1);
  endtask

  task automatic t_wrap();
    do_reset();
    count = 32'hFFFF_FF00;
    @(negedge clk); en_alm = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'hFFFF_FFF0);
    chk("R3 no match before wrapped target", flag_alm, 0);
    set_cnt(32'h0000_02FF);
    chk("R3 no match one below wrapped target", flag_alm, 0);
    set_cnt(32'h0000_0300);
    chk("R3 match at wrapped target", flag_alm, 1);
  endtask

  task automatic t_update();
    do_reset();
    sec = 6'd5;
    @(negedge clk); en_upd = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd1024);
    chk("R6 first sample silent", flag_upd, 0);
    set_cnt(32'd2048);
    chk("R6 same seconds silent", flag_upd, 0);
    @(negedge clk); sec = 6'd6;
    set_cnt(32'd3072);
    chk("R6 seconds change fires", flag_upd, 1);
  endtask

  task automatic t_rearm();
    do_reset();
    @(negedge clk); en_alm = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd4106);
    chk("R4 match after jump", flag_alm, 1);
    chk("R4 lost count", lost, 3);
    pulse_ack();
    set_cnt(32'd5119);
    chk("R4 no match before final target", flag_alm, 0);
    set_cnt(32'd5120);
    chk("R4 match at final target", flag_alm, 1);
  endtask

  task automatic t_sat();
    do_reset();
    @(negedge clk); en_alm = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd308224);
    repeat (320) @(negedge clk);
    chk("R5 lost saturates", lost, 255);
  endtask

  task automatic t_per_low();
    do_reset();
    rate = 4'd4;
    @(negedge clk); en_per = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd1024);
    set_cnt(32'd2048);
    set_cnt(32'd3072);
    chk("R8 no periodic before 4th match", flag_per, 0);
    set_cnt(32'd4096);
    chk("R8 periodic on 4th match", flag_per, 1);
  endtask

  task automatic t_per_high();
    do_reset();
    rate = 4'd9;
    @(negedge clk); en_per = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd127);
    chk("R9 no match before short interval", flag_per, 0);
    set_cnt(32'd128);
    chk("R9 periodic at short interval", flag_per, 1);
    pulse_ack();
    set_cnt(32'd255);
    chk("R9 no match before second interval", flag_per, 0);
    set_cnt(32'd256);
    chk("R9 periodic every match", flag_per, 1);
  endtask

  task automatic t_lost_per();
    do_reset();
    rate = 4'd3;
    @(negedge clk); en_per = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd5120);
    chk("R10 lost four", lost, 4);
    chk("R10 divider at 5 no fire", flag_per, 0);
    set_cnt(32'd6144);
    set_cnt(32'd7168);
    chk("R10 divider at 7 no fire", flag_per, 0);
    set_cnt(32'd8192);
    chk("R10 fires with lost credit", flag_per, 1);
  endtask

  task automatic t_idle();
    do_reset();
    set_cnt(32'd5000);
    set_cnt(32'd100000);
    chk("R11 off no irq", irq, 0);
    chk("R11 off lost unchanged", lost, 0);
    @(negedge clk); en_alm = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd101024);
    chk("R11 enabled fires", flag_alm, 1);
    @(negedge clk); en_alm = 1'b0;
    pulse_ack();
    set_cnt(32'd150000);
    set_cnt(32'd200000);
    chk("R11 disabled no flag", flag_alm, 0);
    chk("R11 disabled no irq", irq, 0);
    @(negedge clk); en_alm = 1'b1;
    repeat (3) @(negedge clk);
    set_cnt(32'd201023);
    chk("R2 re-arm relative to counter", flag_alm, 0);
    set_cnt(32'd201024);
    chk("R2 re-arm match", flag_alm, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_arm();
    t_alarm_mismatch();
    t_wrap();
    t_update();
    t_rearm();
    t_sat();
    t_per_low();
    t_per_high();
    t_lost_per();
    t_idle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule